// File: doc/BRIEF.md
# Memory Single-Bit Clear Unit

This unit clears one bit of a byte held in memory as a single indivisible read-modify-write. A start strobe launches an operation. The unit reads the addressed byte through a synchronous byte-wide memory port. It reports whether the selected bit was already clear on a Z output qualified by a write enable. It then stores the byte back with that bit forced to zero. No other memory access is made between the read and the write.

Two addressing forms are supported, chosen by a form select at start. In the displacement form, the byte address is a base register value plus a sign-extended 16-bit displacement, and the bit number is a 3-bit immediate. In the register form, the base register value is the address with no displacement, and the bit number is the low three bits of a second register value. The Z flag is the only condition flag the unit updates.

Top module: `bitclr_rmw`

## Requirements
- R1: With `form_reg`=0, the memory address is `base_val` + sign-extend(`disp`) modulo 2^32, and the bit number is `bit_imm`.
- R2: With `form_reg`=1, the memory address is `base_val` unchanged, the bit number is `bitreg_val[2:0]`, and bits 31:3 of `bitreg_val` have no effect.
- R3: In the write cycle, `z_we` is 1 and `z_out` is 1 exactly when the selected bit of the byte that was read was 0. `z_we` is 0 in every other cycle.
- R4: The written byte `mem_wdata` equals the byte that was read with the selected bit set to 0 and the other seven bits unchanged.
- R5: The operation takes 3 clocks. `mem_rd` is high in the cycle after start is accepted, the next cycle has no access, and in the third cycle `mem_wr`, `done` and `z_we` are high together.
- R6: Each operation makes exactly one read and then one write to the same address. `mem_rd` and `mem_wr` are never high together, and no access happens while the unit is idle.
- R7: A start strobe that arrives while an operation is in progress is ignored. The operation in progress keeps its address and its data, and no second operation follows.
- R8: During and right after synchronous reset, `mem_rd`, `mem_wr`, `done` and `z_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (taken only when idle) |
| form_reg | input | 1 | 0: base + displacement with immediate bit number; 1: base only with register bit number |
| base_val | input | 32 | Base register value |
| bitreg_val | input | 32 | Bit-number register value (register form) |
| disp | input | 16 | Signed displacement (displacement form) |
| bit_imm | input | 3 | Immediate bit number (displacement form) |
| mem_addr | output | 32 | Byte address for the memory port |
| mem_rd | output | 1 | Read request; data returns the next cycle |
| mem_wr | output | 1 | Write request |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| z_out | output | 1 | New Z flag value |
| z_we | output | 1 | Z flag update enable |
| done | output | 1 | Operation completes this cycle |

## Verification
On every cycle the assertions check that a read and a write never coincide. They check the read, idle, write spacing, and that the write reuses the read address. They also check that the written byte differs from the returned byte in at most one bit, and only by clearing it, and that Z agrees with whether that bit changed. Only the bench scenarios can show that the correct bit was chosen and that the correct address was formed for each form and displacement sign. The bench scenarios also show that the upper bits of the register bit number are ignored and that a start during a busy operation leaves memory untouched.

// File: rtl/bitclr_pkg.sv
package bitclr_pkg;

    localparam int REG_W  = 32;
    localparam int DISP_W = 16;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_MERGE = 2'd2,
        PH_WRITE = 2'd3
    } phase_t;

    typedef struct packed {
        logic [REG_W-1:0] addr;
        logic [BIT_W-1:0] bsel;
    } target_t;

    function automatic logic [REG_W-1:0] sext_disp(input logic [DISP_W-1:0] d);
        return {{(REG_W-DISP_W){d[DISP_W-1]}}, d};
    endfunction

    function automatic logic [BYTE_W-1:0] clear_bit(input logic [BYTE_W-1:0] b,
                                                     input logic [BIT_W-1:0]  n);
        logic [BYTE_W-1:0] mask;
        mask = '0;
        mask[n] = 1'b1;
        return b & ~mask;
    endfunction

endpackage

// File: rtl/bitclr_target.sv
module bitclr_target
    import bitclr_pkg::*;
(
    input  logic              form_reg,
    input  logic [REG_W-1:0]  base_val,
    input  logic [REG_W-1:0]  bitreg_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [BIT_W-1:0]  bit_imm,
    output target_t           tgt
);
    always_comb begin
        if (form_reg) begin
            tgt.addr = base_val;
            tgt.bsel = bitreg_val[BIT_W-1:0];
        end else begin
            tgt.addr = base_val + sext_disp(disp);
            tgt.bsel = bit_imm;
        end
    end
endmodule

// File: rtl/bitclr_seq.sv
module bitclr_seq
    import bitclr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output logic   accept,
    output phase_t phase
);
    phase_t phase_nx;

    assign accept = start && (phase == PH_IDLE);

    always_comb begin
        case (phase)
            PH_IDLE:  phase_nx = accept ? PH_READ : PH_IDLE;
            PH_READ:  phase_nx = PH_MERGE;
            PH_MERGE: phase_nx = PH_WRITE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end
endmodule

// File: rtl/bitclr_merge.sv
module bitclr_merge
    import bitclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BYTE_W-1:0] rdata,
    input  logic [BIT_W-1:0]  bsel,
    output logic [BYTE_W-1:0] wdata,
    output logic              z_new
);
    logic [BYTE_W-1:0] old_byte;

    always_ff @(posedge clk) begin
        if (rst)          old_byte <= '0;
        else if (capture) old_byte <= rdata;
    end

    assign wdata = clear_bit(old_byte, bsel);
    assign z_new = ~old_byte[bsel];
endmodule

// File: rtl/bitclr_rmw.sv
module bitclr_rmw
    import bitclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              form_reg,
    input  logic [REG_W-1:0]  base_val,
    input  logic [REG_W-1:0]  bitreg_val,
    input  logic [DISP_W-1:0] disp,
    input  logic [BIT_W-1:0]  bit_imm,
    output logic [REG_W-1:0]  mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              z_out,
    output logic              z_we,
    output logic              done
);
    target_t tgt_nx;
    target_t tgt_q;
    phase_t  phase;
    logic    accept;

    bitclr_target u_target (
        .form_reg   (form_reg),
        .base_val   (base_val),
        .bitreg_val (bitreg_val),
        .disp       (disp),
        .bit_imm    (bit_imm),
        .tgt        (tgt_nx)
    );

    bitclr_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .accept (accept),
        .phase  (phase)
    );

    always_ff @(posedge clk) begin
        if (rst)         tgt_q <= '0;
        else if (accept) tgt_q <= tgt_nx;
    end

    bitclr_merge u_merge (
        .clk     (clk),
        .rst     (rst),
        .capture (phase == PH_MERGE),
        .rdata   (mem_rdata),
        .bsel    (tgt_q.bsel),
        .wdata   (mem_wdata),
        .z_new   (z_out)
    );

    assign mem_addr = tgt_q.addr;
    assign mem_rd   = (phase == PH_READ);
    assign mem_wr   = (phase == PH_WRITE);
    assign done     = (phase == PH_WRITE);
    assign z_we     = (phase == PH_WRITE);
endmodule

// File: rtl/bitclr_rmw_chk.sv
module bitclr_rmw_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] mem_addr,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic [7:0]  mem_wdata,
    input logic [7:0]  mem_rdata,
    input logic        z_out,
    input logic        z_we,
    input logic        done
);
    p_rd_wr_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    p_gap_after_rd_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (!mem_rd && !mem_wr && !done));

    p_wr_follows_rd_r5: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> ##1 (mem_wr && done && z_we));

    p_same_addr_r6: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> ##1 (mem_addr == $past(mem_addr, 2)));

    p_clear_only_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ((mem_wdata & ~$past(mem_rdata)) == 8'h00));

    p_one_bit_r4: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));

    p_z_value_r3: assert property (@(posedge clk) disable iff (rst)
        z_we |-> (z_out == (mem_wdata == $past(mem_rdata))));

    p_after_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> (!mem_rd && !mem_wr && !done && !z_we));
endmodule

bind bitclr_rmw bitclr_rmw_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .z_out     (z_out),
    .z_we      (z_we),
    .done      (done)
);

// File: tb/bitclr_rmw_tb.sv
module bitclr_rmw_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        form_reg;
    logic [31:0] base_val;
    logic [31:0] bitreg_val;
    logic [15:0] disp;
    logic [2:0]  bit_imm;
    logic [31:0] mem_addr;
    logic        mem_rd;
    logic        mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        z_out;
    logic        z_we;
    logic        done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] mem [0:255];

    always #5 clk = ~clk;

    bitclr_rmw u_dut (
        .clk(clk), .rst(rst), .start(start), .form_reg(form_reg),
        .base_val(base_val), .bitreg_val(bitreg_val), .disp(disp), .bit_imm(bit_imm),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .z_out(z_out), .z_we(z_we), .done(done)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_op(input bit f, input logic [31:0] b, input logic [31:0] br,
                          input logic [15:0] d, input logic [2:0] bi,
                          input logic [7:0] preset, input bit poke);
        logic [31:0] ea;
        logic [2:0]  bn;
        logic [7:0]  expw;
        string       rq;
        ea   = f ? b : b + {{16{d[15]}}, d};
        bn   = f ? br[2:0] : bi;
        expw = preset & ~(8'h01 << bn);
        rq   = f ? "R2" : "R1";
        mem[ea[7:0]] = preset;
        form_reg = f; base_val = b; bitreg_val = br; disp = d; bit_imm = bi;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_rd && !mem_wr, "R5 read cycle", {30'd0, mem_rd, mem_wr}, 32'h2);
        chk(mem_addr == ea, rq, mem_addr, ea);
        if (poke) begin
            start = 1'b1; form_reg = ~f; base_val = b ^ 32'h0000_0055;
            bitreg_val = br ^ 32'h7; bit_imm = ~bi;
        end
        @(negedge clk);
        start = 1'b0;
        chk(!mem_rd && !mem_wr && !done && !z_we, "R6 gap cycle",
            {28'd0, mem_rd, mem_wr, done, z_we}, 32'h0);
        if (poke) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(mem_wr && done && z_we && !mem_rd, "R5 write cycle",
            {28'd0, mem_rd, mem_wr, done, z_we}, 32'h7);
        chk(mem_addr == ea, poke ? "R7 address held" : "R6 write address", mem_addr, ea);
        chk(mem_wdata == expw, poke ? "R7 data held" : "R4 write data",
            {24'd0, mem_wdata}, {24'd0, expw});
        chk(z_out == ~preset[bn], "R3 z value", {31'd0, z_out}, {31'd0, ~preset[bn]});
        @(negedge clk);
        chk(!mem_rd && !mem_wr && !done && !z_we, poke ? "R7 no second op" : "R6 idle",
            {28'd0, mem_rd, mem_wr, done, z_we}, 32'h0);
        chk(mem[ea[7:0]] == expw, "R4 memory byte", {24'd0, mem[ea[7:0]]}, {24'd0, expw});
        @(negedge clk);
        chk(!mem_rd && !mem_wr, "R7 still idle", {30'd0, mem_rd, mem_wr}, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
        rst = 1'b1; start = 1'b0; form_reg = 1'b0; base_val = '0;
        bitreg_val = '0; disp = '0; bit_imm = '0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        chk(!mem_rd && !mem_wr && !done && !z_we, "R8 in reset",
            {28'd0, mem_rd, mem_wr, done, z_we}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!mem_rd && !mem_wr && !done && !z_we, "R8 after reset",
            {28'd0, mem_rd, mem_wr, done, z_we}, 32'h0);
        for (int f = 0; f < 2; f++) begin
            for (int bn = 0; bn < 8; bn++) begin
                for (int p = 0; p < 5; p++) begin
                    logic [7:0]  pat;
                    logic [31:0] bse;
                    logic [15:0] dsp;
                    case (p)
                        0: pat = 8'hFF;
                        1: pat = 8'h00;
                        2: pat = 8'hA5;
                        3: pat = 8'h5A;
                        default: pat = 8'(1 << bn);
                    endcase
                    bse = 32'h0001_2000 + 32'(bn * 16 + p);
                    dsp = (p[0]) ? 16'hFF90 : 16'h0043;
                    run_op(f[0], bse, {29'h1ABCDEF, 3'(bn)} ^ 32'h8000_0000 * p,
                           dsp, 3'(bn), pat, p == 2);
                end
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule